// File: doc/BRIEF.md
# Configurable Up/Down/Center-Aligned Timer Counter

This block is the counting core of a general-purpose timer. A small register port sets a control word, a reload limit and a compare value. The port can also load the counter and read all four registers back. On every timer clock with the run bit set, the counter steps in one of four ways. It can count up and wrap to zero. It can count down and reload from the limit. In three center-aligned modes it swings between zero and the limit. Each wrap or turning point gives a one-cycle update pulse. A compare pulse fires when the count equals the compare value, but only in the count directions that the mode allows.

The reload limit can be double-buffered, so a new limit starts only at the next update. A one-shot option clears the run bit at the first update. A free-running divider gives a sampling enable that downstream input filters can use. The enable pulses every one, two or four clocks.

Top module: `tmrCore`

## Requirements
- R1: After reset the control word reads 0x0000, the limit reads 0xFFFF, the compare value and the count read 0, and updateEvt and cmpFlag are low. Control bits 15:8 always read 0.
- R2: Edge mode counting up (control bits 4:3 = 00, bit 2 = 0): the count goes 0,1,…,limit and then 0, with an update pulse on each wrap.
- R3: Edge mode counting down (bits 4:3 = 00, bit 2 = 1): the count goes down to 0 and then reloads the limit, with an update pulse on each reload.
- R4: In the center modes (bits 4:3 ≠ 00) the count runs 0→limit→0 and repeats. An update pulse marks each turning point, and countDown shows the current direction.
- R5: cmpFlag pulses one clock after a cycle in which the count equals the compare value, subject to direction. Edge mode allows both directions. Mode 01 allows down only, mode 10 allows up only, and mode 11 allows both.
- R6: With bit 5 = 1, a written limit takes effect at the next update. With bit 5 = 0, it takes effect at the write.
- R7: With bit 1 = 1, the first update clears the run bit (bit 0) and the count stops.
- R8: A control write that selects a center mode is ignored as a whole if the counter is running in edge mode.
- R9: In the center modes a write cannot change the direction bit. Bit 2 reads back the live count direction.
- R10: sampleEn pulses every 1, 2 or 4 clocks for bits 7:6 = 00, 01 or 10. The value 11 acts as 10.
- R11: With a limit of 0 the count stays at 0, and an update pulse comes on every running clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 limit, 2 compare, 3 count |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address, same map as wrAddr |
| rdData | output | 16 | Combinational read data |
| updateEvt | output | 1 | One-cycle update pulse |
| countDown | output | 1 | Current count direction, 1 = down |
| cmpFlag | output | 1 | One-cycle compare pulse |
| sampleEn | output | 1 | Filter sampling enable |

## Verification
The compare match and the update can happen in the same cycle. This occurs when the compare value equals the limit or zero, since those are the turning points. Vectors place the compare value on the top turning point in the center modes. Mode 01 must then give no compare pulses while mode 11 gives one per pass. A limit of zero makes both pulses fire on every clock. Each case is judged by counting the pulses over a fixed window and comparing them with values worked out by hand.

// File: rtl/tmrPkg.sv
package tmrPkg;
  typedef enum logic [1:0] {
    ALIGN_EDGE = 2'b00,
    ALIGN_DN   = 2'b01,
    ALIGN_UP   = 2'b10,
    ALIGN_BOTH = 2'b11
  } alignE;

  typedef struct packed {
    logic run;
    logic center;
    logic edgeDown;
    logic gateUp;
    logic gateDown;
    logic loadCnt;
  } stbT;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_ARR  = 2'd1;
  localparam logic [1:0] ADR_CMP  = 2'd2;
  localparam logic [1:0] ADR_CNT  = 2'd3;
endpackage

// File: rtl/tmrCtrl.sv
module tmrCtrl
  import tmrPkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [CW-1:0] wrData,
  input  logic [1:0]    rdAddr,
  input  logic          wrapNow,
  input  logic          dirState,
  input  logic [CW-1:0] cntVal,
  output stbT           stb,
  output logic [CW-1:0] arrActive,
  output logic [CW-1:0] cmpVal,
  output logic [1:0]    sampleDiv,
  output logic [CW-1:0] rdData
);
  localparam int PADW = CW - 8;

  logic          runQ, oneShotQ, dirQ, bufQ;
  alignE         modeQ, newMode;
  logic [1:0]    divQ;
  logic [CW-1:0] arrPre, arrAct, cmpQ;
  logic          wrCtrl, wrArr, wrCmp, illegal, dirRead;

  assign wrCtrl  = wrEn && (wrAddr == ADR_CTRL);
  assign wrArr   = wrEn && (wrAddr == ADR_ARR);
  assign wrCmp   = wrEn && (wrAddr == ADR_CMP);
  assign newMode = alignE'(wrData[4:3]);
  assign illegal = runQ && (modeQ == ALIGN_EDGE) && (newMode != ALIGN_EDGE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      oneShotQ <= 1'b0;
      dirQ     <= 1'b0;
      modeQ    <= ALIGN_EDGE;
      bufQ     <= 1'b0;
      divQ     <= 2'b00;
    end else if (wrCtrl && !illegal) begin
      runQ     <= wrData[0];
      oneShotQ <= wrData[1];
      if (newMode == ALIGN_EDGE) dirQ <= wrData[2];
      modeQ    <= newMode;
      bufQ     <= wrData[5];
      divQ     <= wrData[7:6];
    end else if (wrapNow && oneShotQ) begin
      runQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrPre <= '1;
      arrAct <= '1;
      cmpQ   <= '0;
    end else begin
      if (wrapNow) arrAct <= arrPre;
      if (wrArr) begin
        arrPre <= wrData;
        if (!bufQ) arrAct <= wrData;
      end
      if (wrCmp) cmpQ <= wrData;
    end
  end

  assign stb.run      = runQ;
  assign stb.center   = (modeQ != ALIGN_EDGE);
  assign stb.edgeDown = dirQ;
  assign stb.gateUp   = (modeQ == ALIGN_EDGE) || (modeQ == ALIGN_UP) || (modeQ == ALIGN_BOTH);
  assign stb.gateDown = (modeQ == ALIGN_EDGE) || (modeQ == ALIGN_DN) || (modeQ == ALIGN_BOTH);
  assign stb.loadCnt  = wrEn && (wrAddr == ADR_CNT);

  assign arrActive = arrAct;
  assign cmpVal    = cmpQ;
  assign sampleDiv = divQ;
  assign dirRead   = (modeQ != ALIGN_EDGE) ? dirState : dirQ;

  always_comb begin
    case (rdAddr)
      ADR_CTRL: rdData = {{PADW{1'b0}}, divQ, bufQ, modeQ, dirRead, oneShotQ, runQ};
      ADR_ARR:  rdData = arrPre;
      ADR_CMP:  rdData = cmpQ;
      default:  rdData = cntVal;
    endcase
  end

  // R7: a one-shot run ends at its first update
  a_r7_oneshot_stops: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && oneShotQ && wrapNow && !wrCtrl) |=> !runQ);

  // R8: a running edge-mode counter never enters a center mode
  a_r8_no_center_switch: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && modeQ == ALIGN_EDGE) |=> (modeQ == ALIGN_EDGE));

  // R6: an unbuffered limit write is live on the next cycle
  a_r6_unbuffered_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrArr && !bufQ) |=> (arrAct == $past(wrData)));
endmodule

// File: rtl/tmrPath.sv
module tmrPath
  import tmrPkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  stbT           stb,
  input  logic [CW-1:0] loadVal,
  input  logic [CW-1:0] arrActive,
  input  logic [CW-1:0] cmpVal,
  input  logic [1:0]    sampleDiv,
  output logic [CW-1:0] cntQ,
  output logic          dirState,
  output logic          countDown,
  output logic          wrapNow,
  output logic          updateEvt,
  output logic          cmpFlag,
  output logic          sampleEn
);
  localparam logic [CW-1:0] ONE = 1;

  logic          dirDnQ, atTop, atBot, turn, goingDown, match;
  logic [CW-1:0] nextCnt;
  logic [1:0]    divCnt, divMask;

  assign atTop     = (cntQ >= arrActive);
  assign atBot     = (cntQ == '0);
  assign goingDown = stb.center ? dirDnQ : stb.edgeDown;
  assign turn      = goingDown ? atBot : atTop;
  assign wrapNow   = stb.run && turn && !stb.loadCnt;
  assign match     = (cntQ == cmpVal) && (goingDown ? stb.gateDown : stb.gateUp);

  always_comb begin
    if (!stb.center) begin
      if (stb.edgeDown) nextCnt = atBot ? arrActive : cntQ - ONE;
      else              nextCnt = atTop ? '0 : cntQ + ONE;
    end else if (dirDnQ) begin
      nextCnt = atBot ? ((arrActive == '0) ? '0 : ONE) : cntQ - ONE;
    end else begin
      nextCnt = atTop ? (atBot ? '0 : cntQ - ONE) : cntQ + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ      <= '0;
      dirDnQ    <= 1'b0;
      updateEvt <= 1'b0;
      cmpFlag   <= 1'b0;
    end else begin
      if (stb.loadCnt)  cntQ <= loadVal;
      else if (stb.run) cntQ <= nextCnt;
      if (!stb.center)  dirDnQ <= 1'b0;
      else if (wrapNow) dirDnQ <= ~dirDnQ;
      updateEvt <= wrapNow;
      cmpFlag   <= stb.run && match;
    end
  end

  always_comb begin
    case (sampleDiv)
      2'b00:   divMask = 2'b00;
      2'b01:   divMask = 2'b01;
      default: divMask = 2'b11;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= 2'b00;
    else       divCnt <= divCnt + 2'b01;
  end

  assign sampleEn  = ((divCnt & divMask) == divMask);
  assign dirState  = dirDnQ;
  assign countDown = goingDown;

  // R2: edge up-counting below the limit advances by one
  a_r2_up_step: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.center && !stb.edgeDown && !stb.loadCnt && !atTop)
    |=> (cntQ == $past(cntQ) + ONE));

  // R3: edge down-counting at zero reloads the limit
  a_r3_down_reload: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.center && stb.edgeDown && !stb.loadCnt && atBot)
    |=> (cntQ == $past(arrActive)));

  // R4: an update pulse only follows a running cycle
  a_r4_update_running: assert property (@(posedge clk) disable iff (!rstN)
    updateEvt |-> $past(stb.run));

  // R5: with up-gating off in a center mode, a flag means the count was falling
  a_r5_flag_gate: assert property (@(posedge clk) disable iff (!rstN)
    (cmpFlag && $past(stb.center) && !$past(stb.gateUp)) |-> $past(dirDnQ));

  // R10: at divide-by-four, two enables are never adjacent
  a_r10_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && sampleDiv == 2'b10 && $past(sampleDiv) == 2'b10) |-> !$past(sampleEn));
endmodule

// File: rtl/tmrCore.sv
module tmrCore
  import tmrPkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [1:0]    wrAddr,
  input  logic [CW-1:0] wrData,
  input  logic [1:0]    rdAddr,
  output logic [CW-1:0] rdData,
  output logic          updateEvt,
  output logic          countDown,
  output logic          cmpFlag,
  output logic          sampleEn
);
  stbT           stb;
  logic [CW-1:0] arrActive, cmpVal, cntQ;
  logic [1:0]    sampleDiv;
  logic          wrapNow, dirState;

  tmrCtrl #(.CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .wrapNow(wrapNow), .dirState(dirState), .cntVal(cntQ),
    .stb(stb), .arrActive(arrActive), .cmpVal(cmpVal), .sampleDiv(sampleDiv),
    .rdData(rdData)
  );

  tmrPath #(.CW(CW)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(wrData), .arrActive(arrActive),
    .cmpVal(cmpVal), .sampleDiv(sampleDiv), .cntQ(cntQ), .dirState(dirState),
    .countDown(countDown), .wrapNow(wrapNow), .updateEvt(updateEvt),
    .cmpFlag(cmpFlag), .sampleEn(sampleEn)
  );
endmodule

// File: tb/tb_tmrCore.sv
module tb_tmrCore;
  localparam int CW = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_ARR = 2'd1, A_CMP = 2'd2, A_CNT = 2'd3;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [CW-1:0] wrData = '0;
  logic [CW-1:0] rdData;
  logic updateEvt, countDown, cmpFlag, sampleEn;

  tmrCore #(.CW(CW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .updateEvt(updateEvt),
    .countDown(countDown), .cmpFlag(cmpFlag), .sampleEn(sampleEn)
  );

  always #5 clk = ~clk;

  int nChk = 0, nBad = 0;

  task automatic chk(string tag, int got, int exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the capture
  task automatic wr(logic [1:0] a, logic [15:0] d);
    wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    rdAddr = a; #1; v = int'(rdData);
  endtask

  typedef struct packed {
    logic [15:0] ctrl, arr, cmp, start;
    logic [7:0]  n;
    logic [15:0] eCnt;
    logic [7:0]  eUpd, eFlg;
    logic        eDir;
    logic [15:0] eCtrl;
  } vecT;

  localparam vecT VECS [9] = '{
    '{16'h0001, 16'd4, 16'd2, 16'd0, 8'd12, 16'd2, 8'd2, 8'd2, 1'b0, 16'h0001}, // R2 edge up
    '{16'h0005, 16'd3, 16'd1, 16'd3, 8'd10, 16'd1, 8'd2, 8'd2, 1'b1, 16'h0005}, // R3 edge down
    '{16'h0009, 16'd3, 16'd2, 16'd0, 8'd12, 16'd0, 8'd3, 8'd2, 1'b1, 16'h000D}, // R4 R5 mode 01
    '{16'h0011, 16'd3, 16'd2, 16'd0, 8'd12, 16'd0, 8'd3, 8'd2, 1'b1, 16'h0015}, // R5 mode 10
    '{16'h0019, 16'd3, 16'd2, 16'd0, 8'd12, 16'd0, 8'd3, 8'd4, 1'b1, 16'h001D}, // R5 mode 11
    '{16'h0009, 16'd3, 16'd3, 16'd0, 8'd12, 16'd0, 8'd3, 8'd0, 1'b1, 16'h000D}, // R5 match at top, down-only
    '{16'h0003, 16'd3, 16'd9, 16'd0, 8'd10, 16'd0, 8'd1, 8'd0, 1'b0, 16'h0002}, // R7 one-shot edge
    '{16'h000B, 16'd2, 16'd9, 16'd0, 8'd6,  16'd1, 8'd1, 8'd0, 1'b1, 16'h000E}, // R7 one-shot center
    '{16'h0001, 16'd0, 16'd0, 16'd0, 8'd5,  16'd0, 8'd5, 8'd5, 1'b0, 16'h0001}  // R11 zero limit
  };

  vecT v;
  int r, upd, flg, se;

  initial begin
    #1_000_000;
    nBad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, r); chk("R1 ctrl reset", r, 0);
    rd(A_ARR, r);  chk("R1 limit reset", r, 16'hFFFF);
    rd(A_CMP, r);  chk("R1 compare reset", r, 0);
    rd(A_CNT, r);  chk("R1 count reset", r, 0);
    chk("R1 updateEvt low", int'(updateEvt), 0);
    chk("R1 cmpFlag low", int'(cmpFlag), 0);
    @(negedge clk);
    wr(A_CTRL, 16'hFF00);
    rd(A_CTRL, r); chk("R1 upper control bits read zero", r, 0);
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      v = VECS[i];
      wr(A_CTRL, 16'h0000);
      wr(A_ARR, v.arr);
      wr(A_CMP, v.cmp);
      wr(A_CNT, v.start);
      wr(A_CTRL, v.ctrl);
      upd = 0; flg = 0;
      for (int k = 0; k < int'(v.n); k++) begin
        @(negedge clk);
        if (updateEvt) upd++;
        if (cmpFlag) flg++;
      end
      rd(A_CNT, r);  chk($sformatf("vector %0d count", i), r, int'(v.eCnt));
      chk($sformatf("vector %0d update pulses", i), upd, int'(v.eUpd));
      chk($sformatf("vector %0d compare pulses", i), flg, int'(v.eFlg));
      chk($sformatf("vector %0d countDown", i), int'(countDown), int'(v.eDir));
      rd(A_CTRL, r); chk($sformatf("vector %0d control readback", i), r, int'(v.eCtrl));
      @(negedge clk);
    end

    // R6 unbuffered limit applies at once
    wr(A_CTRL, 16'h0000); wr(A_ARR, 16'd2); wr(A_CNT, 16'd0);
    wr(A_CTRL, 16'h0001); wr(A_ARR, 16'd6);
    repeat (8) @(negedge clk);
    rd(A_CNT, r); chk("R6 unbuffered limit immediate", r, 2);
    @(negedge clk);

    // R6 buffered limit waits for the next update
    wr(A_CTRL, 16'h0000); wr(A_ARR, 16'd2); wr(A_CNT, 16'd0);
    wr(A_CTRL, 16'h0021); wr(A_ARR, 16'd6);
    repeat (8) @(negedge clk);
    rd(A_CNT, r); chk("R6 buffered limit deferred", r, 6);
    @(negedge clk);

    // R8 switch to center while running in edge mode is dropped
    wr(A_CTRL, 16'h0000); wr(A_ARR, 16'd100); wr(A_CNT, 16'd0);
    wr(A_CTRL, 16'h0001); wr(A_CTRL, 16'h0009);
    rd(A_CTRL, r); chk("R8 illegal switch ignored", r, 16'h0001);
    @(negedge clk);

    // R9 direction bit not writable in center mode
    wr(A_CTRL, 16'h0000); wr(A_CNT, 16'd0);
    wr(A_CTRL, 16'h0009); wr(A_CTRL, 16'h000D);
    rd(A_CTRL, r); chk("R9 direction bit read-only", r, 16'h0009);
    chk("R9 countDown still up", int'(countDown), 0);
    @(negedge clk);
    wr(A_CTRL, 16'h0000);

    // R10 sampling enable rates
    for (int d = 0; d < 3; d++) begin
      wr(A_CTRL, 16'(d << 6));
      se = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (sampleEn) se++;
      end
      chk($sformatf("R10 sample pulses div code %0d", d), se, 8 >> d);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule